// File: doc/BRIEF.md
# DMA Channel Control Registers with Coalesced Completion Interrupts

This block holds the software-visible registers and interrupt logic of a single DMA channel. A descriptor engine sits beside it. The engine fetches descriptors and moves data, and it reports back with three event inputs: packet completed, out of work (idle) and stopped (halted). The block turns register writes into control for that engine. A write of the tail pointer produces a one-cycle start pulse. A write of the current pointer produces a one-cycle reload pulse and the new pointer value. The run, idle and halted indications come from a small channel state machine.

Completion interrupts are coalesced. A packet counter is loaded from a threshold field and counts down once per completed packet. When it reaches zero, the completion interrupt is latched and the counter is reloaded. A second source is a delay timer. Each completion restarts it from a delay field when that field is nonzero, and the timer counts down once every `PRESCALE` clock cycles. When it expires, the delay interrupt is latched and the packet counter is reloaded. The live counter and timer values can be read in the upper bytes of the status word. A chip that needs two channels places two copies and steers accesses to one or the other with a single address bit.

The channel state machine has four states. HALTED is entered at reset, on an engine halt event, and when a soft reset ends. RUNNING is entered from HALTED or IDLE when run is written as 1, and from IDLE when the tail pointer is written. IDLE is entered from RUNNING on an engine idle event. RESET is entered from any state on a control write with bit 2 set, and it lasts `RESET_CYC` cycles. In every state except RESET, an engine halt event has priority over an idle event and over a run write.

Top module: `dmachan_regs`

## Requirements
- R1: After reset, control (word 0) reads 0x0001_0002, status (word 1) reads 0x0001_0001, irq is 0, chan_halted is 1 and chan_run is 0.
- R2: A control write stores the value with bit 1 always reading 1. It reloads the packet counter, which is visible in status bits 23:16, from written bits 23:16.
- R3: Writing control with bit 0 = 1 outside soft reset clears status bit 0 (halted) and bit 1 (idle). An engine idle event while running sets bit 1 and chan_idle. An engine halt event sets bit 0 and chan_halted.
- R4: Bus writes to status bits 1:0 have no effect.
- R5: A write to the tail pointer (word 4) clears idle, stores the pointer for read-back and raises tail_kick for exactly one cycle, in the cycle after the write.
- R6: A write to the current pointer (word 2) raises cur_load for one cycle, with cur_ptr carrying the written value, and the pointer reads back.
- R7: Each completion decrements the packet counter. The completion at which it reaches zero sets status bit 12 and reloads the counter from control bits 23:16.
- R8: A completion with control bits 31:24 nonzero loads the delay timer, visible in status bits 31:24, which decrements once every PRESCALE cycles. The completion that loads it counts as cycle 0, and after delay × PRESCALE cycles the timer reaches 0, sets status bit 13 and reloads the packet counter. With the delay field at zero, the timer does not start.
- R9: A completion while the timer is running restarts it from the full delay value.
- R10: Status bits 13:12 clear when 1 is written to them. Writing 0 leaves them set.
- R11: irq is 1 exactly when a status bit among 13:12 is set and the enable at the same position in control is 1.
- R12: A control write with bit 2 set returns control to its reset value and clears both interrupt bits. Control bit 2 then reads 1 for RESET_CYC cycles, during which the channel stays halted and a run write does not start it.
- R13: Word offsets other than 0, 1, 2 and 4 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word index within the channel window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| eng_done | input | 1 | Engine completed one packet |
| eng_idle | input | 1 | Engine reached the tail descriptor |
| eng_halted | input | 1 | Engine stopped |
| chan_run | output | 1 | Control run bit |
| chan_idle | output | 1 | Channel is idle |
| chan_halted | output | 1 | Channel is halted |
| tail_kick | output | 1 | One-cycle start pulse after a tail write |
| cur_load | output | 1 | One-cycle pulse after a current-pointer write |
| cur_ptr | output | 32 | Current descriptor pointer |
| tail_ptr | output | 32 | Tail descriptor pointer |
| irq | output | 1 | Channel interrupt |

## Verification
The bench sweeps the packet threshold from 1 to 4 and checks the counter and the completion flag after every packet. This separates a counter that fires one packet early or late from one that reloads correctly. It sweeps the delay from 1 to 3 and samples one cycle before and exactly at the expected expiry, which catches errors in the prescaler or the terminal count. A second completion in mid-count shows that the timer restarts rather than carrying on, and a zero delay field shows that the timer stays stopped. The state machine is taken through run, idle, tail restart, halt and a soft reset that is overlapped with a run write, and interrupt gating and the clear-on-write bits are checked with the enables on and off.

// File: rtl/dmachan_pkg.sv
package dmachan_pkg;

    typedef enum logic [1:0] {
        CH_HALTED  = 2'd0,
        CH_RUNNING = 2'd1,
        CH_IDLE    = 2'd2,
        CH_RESET   = 2'd3
    } chan_state_e;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned FIELD_W   = 8;

    localparam int unsigned WORD_CTRL = 0;
    localparam int unsigned WORD_STAT = 1;
    localparam int unsigned WORD_CUR  = 2;
    localparam int unsigned WORD_TAIL = 4;

    localparam int unsigned BIT_RUN   = 0;
    localparam int unsigned BIT_SRST  = 2;
    localparam int unsigned IRQ_LO    = 12;
    localparam int unsigned THR_LO    = 16;
    localparam int unsigned DLY_LO    = 24;

    localparam logic [DATA_W-1:0] CTRL_DEFAULT = 32'h0001_0002;

endpackage

// File: rtl/dmachan_fsm.sv
module dmachan_fsm
    import dmachan_pkg::*;
#(
    parameter int unsigned RESET_CYC = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_ctrl,
    input  logic        wr_run,
    input  logic        wr_srst,
    input  logic        wr_tail,
    input  logic        eng_idle,
    input  logic        eng_halted,
    output chan_state_e state,
    output logic        halted,
    output logic        idle,
    output logic        srst_busy
);

    localparam int unsigned RCW = (RESET_CYC > 1) ? $clog2(RESET_CYC) : 1;
    localparam logic [RCW-1:0] RC_LOAD = RCW'(RESET_CYC - 1);

    chan_state_e       nxt;
    logic [RCW-1:0]    rcnt;
    logic              start_req;
    logic              srst_req;

    assign start_req = wr_ctrl && wr_run;
    assign srst_req  = wr_ctrl && wr_srst;

    // next-state logic
    always_comb begin
        nxt = state;
        if (srst_req) begin
            nxt = CH_RESET;
        end else begin
            unique case (state)
                CH_RESET:   if (rcnt == '0) nxt = CH_HALTED;
                CH_HALTED:  if (!eng_halted && start_req) nxt = CH_RUNNING;
                CH_RUNNING: begin
                    if (eng_halted)    nxt = CH_HALTED;
                    else if (eng_idle) nxt = CH_IDLE;
                end
                CH_IDLE: begin
                    if (eng_halted)                  nxt = CH_HALTED;
                    else if (wr_tail || start_req)   nxt = CH_RUNNING;
                end
                default:    nxt = CH_HALTED;
            endcase
        end
    end

    // state register and reset-window counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CH_HALTED;
            rcnt  <= '0;
        end else begin
            state <= nxt;
            if (srst_req)
                rcnt <= RC_LOAD;
            else if (state == CH_RESET && rcnt != '0)
                rcnt <= rcnt - 1'b1;
        end
    end

    // outputs
    always_comb begin
        halted    = (state == CH_HALTED) || (state == CH_RESET);
        idle      = (state == CH_IDLE);
        srst_busy = (state == CH_RESET);
    end

endmodule

// File: rtl/dmachan_coalesce.sv
module dmachan_coalesce #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic [CW-1:0] reload_val,
    input  logic [CW-1:0] thr,
    input  logic          done,
    input  logic          expire,
    output logic [CW-1:0] cnt,
    output logic          hit
);

    localparam logic [CW-1:0] ONE = CW'(1);

    assign hit = done && !reload && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= ONE;
        end else if (reload) begin
            cnt <= reload_val;
        end else if (done) begin
            if (cnt == ONE) cnt <= thr;
            else            cnt <= cnt - 1'b1;
        end else if (expire) begin
            cnt <= thr;
        end
    end

endmodule

// File: rtl/dmachan_delay.sv
module dmachan_delay #(
    parameter int unsigned PRESCALE = 16,
    parameter int unsigned DW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] cnt,
    output logic          expire
);

    localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pre;
    logic          start;
    logic          tick;

    assign start  = load && (load_val != '0);
    assign tick   = (cnt != '0) && (pre == PRE_LAST);
    assign expire = tick && (cnt == DW'(1)) && !start && !clear;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
            pre <= '0;
        end else if (start) begin
            cnt <= load_val;
            pre <= '0;
        end else if (cnt != '0) begin
            if (tick) begin
                pre <= '0;
                cnt <= cnt - 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dmachan_regs.sv
module dmachan_regs
    import dmachan_pkg::*;
#(
    parameter int unsigned PRESCALE  = 16,
    parameter int unsigned RESET_CYC = 4,
    parameter int unsigned ADDR_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                eng_done,
    input  logic                eng_idle,
    input  logic                eng_halted,
    output logic                chan_run,
    output logic                chan_idle,
    output logic                chan_halted,
    output logic                tail_kick,
    output logic                cur_load,
    output logic [DATA_W-1:0]   cur_ptr,
    output logic [DATA_W-1:0]   tail_ptr,
    output logic                irq
);

    localparam int unsigned NIRQ = 2;

    logic                wr_ctrl, wr_stat, wr_cur, wr_tail;
    logic                srst_wr;
    logic [DATA_W-1:0]   ctrl_q;
    logic [NIRQ-1:0]     pend_q;
    logic [NIRQ-1:0]     w1c;
    logic [FIELD_W-1:0]  coal_cnt, dly_cnt;
    logic [FIELD_W-1:0]  reload_val;
    logic                coal_hit, dly_expire;
    logic                srst_busy;
    logic                tail_kick_q, cur_load_q;
    chan_state_e         state;

    assign wr_ctrl = reg_wr_en && (reg_addr == ADDR_W'(WORD_CTRL));
    assign wr_stat = reg_wr_en && (reg_addr == ADDR_W'(WORD_STAT));
    assign wr_cur  = reg_wr_en && (reg_addr == ADDR_W'(WORD_CUR));
    assign wr_tail = reg_wr_en && (reg_addr == ADDR_W'(WORD_TAIL));
    assign srst_wr = wr_ctrl && reg_wdata[BIT_SRST];

    dmachan_fsm #(.RESET_CYC(RESET_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wr_run     (reg_wdata[BIT_RUN]),
        .wr_srst    (reg_wdata[BIT_SRST]),
        .wr_tail    (wr_tail),
        .eng_idle   (eng_idle),
        .eng_halted (eng_halted),
        .state      (state),
        .halted     (chan_halted),
        .idle       (chan_idle),
        .srst_busy  (srst_busy)
    );

    assign reload_val = srst_wr ? CTRL_DEFAULT[THR_LO +: FIELD_W]
                                : reg_wdata[THR_LO +: FIELD_W];

    dmachan_coalesce #(.CW(FIELD_W)) u_coal (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (wr_ctrl),
        .reload_val (reload_val),
        .thr        (ctrl_q[THR_LO +: FIELD_W]),
        .done       (eng_done),
        .expire     (dly_expire),
        .cnt        (coal_cnt),
        .hit        (coal_hit)
    );

    dmachan_delay #(.PRESCALE(PRESCALE), .DW(FIELD_W)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (srst_wr),
        .load     (eng_done),
        .load_val (ctrl_q[DLY_LO +: FIELD_W]),
        .cnt      (dly_cnt),
        .expire   (dly_expire)
    );

    assign w1c = wr_stat ? reg_wdata[IRQ_LO +: NIRQ] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q      <= CTRL_DEFAULT;
            pend_q      <= '0;
            cur_ptr     <= '0;
            tail_ptr    <= '0;
            tail_kick_q <= 1'b0;
            cur_load_q  <= 1'b0;
        end else begin
            tail_kick_q <= wr_tail;
            cur_load_q  <= wr_cur;
            if (wr_ctrl) begin
                if (srst_wr) ctrl_q <= CTRL_DEFAULT;
                else         ctrl_q <= (reg_wdata & ~(DATA_W'(1) << BIT_SRST))
                                       | CTRL_DEFAULT & DATA_W'(2);
            end
            if (srst_wr) pend_q <= '0;
            else         pend_q <= (pend_q & ~w1c) | {dly_expire, coal_hit};
            if (wr_cur)  cur_ptr  <= reg_wdata;
            if (wr_tail) tail_ptr <= reg_wdata;
        end
    end

    assign tail_kick = tail_kick_q;
    assign cur_load  = cur_load_q;
    assign chan_run  = ctrl_q[BIT_RUN];
    assign irq       = |(pend_q & ctrl_q[IRQ_LO +: NIRQ]);

    always_comb begin
        case (reg_addr)
            ADDR_W'(WORD_CTRL): reg_rdata = {ctrl_q[DATA_W-1:3], srst_busy, 1'b1, ctrl_q[0]};
            ADDR_W'(WORD_STAT): reg_rdata = {dly_cnt, coal_cnt, 2'b00, pend_q,
                                             10'd0, chan_idle, chan_halted};
            ADDR_W'(WORD_CUR):  reg_rdata = cur_ptr;
            ADDR_W'(WORD_TAIL): reg_rdata = tail_ptr;
            default:            reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmachan_regs_chk.sv
module dmachan_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tail_kick,
    input logic       eng_halted,
    input logic       chan_halted,
    input logic       irq,
    input logic [1:0] irq_en,
    input logic       eng_done,
    input logic [7:0] dly_cnt,
    input logic       srst_busy,
    input logic       coal_hit,
    input logic [1:0] pend
);

    // R5
    tail_kick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tail_kick |=> !tail_kick);

    // R3
    halt_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_halted |=> chan_halted);

    // R11
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 2'b00) |-> !irq);

    // R8
    dly_down_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_cnt != 8'd0 && !eng_done) |=> (dly_cnt <= $past(dly_cnt)));

    // R12
    srst_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |-> chan_halted);

    // R7
    hit_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coal_hit |=> pend[0]);

endmodule

bind dmachan_regs dmachan_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tail_kick   (tail_kick),
    .eng_halted  (eng_halted),
    .chan_halted (chan_halted),
    .irq         (irq),
    .irq_en      (ctrl_q[13:12]),
    .eng_done    (eng_done),
    .dly_cnt     (dly_cnt),
    .srst_busy   (srst_busy),
    .coal_hit    (coal_hit),
    .pend        (pend_q)
);

// File: tb/dmachan_regs_tb.sv
module dmachan_regs_tb_top;

    localparam int unsigned P  = 3;
    localparam int unsigned RC = 3;
    localparam int unsigned AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          eng_done = 1'b0, eng_idle = 1'b0, eng_halted = 1'b0;
    logic          chan_run, chan_idle, chan_halted, tail_kick, cur_load, irq;
    logic [31:0]   cur_ptr, tail_ptr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dmachan_regs #(.PRESCALE(P), .RESET_CYC(RC), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_done(eng_done),
        .eng_idle(eng_idle), .eng_halted(eng_halted), .chan_run(chan_run),
        .chan_idle(chan_idle), .chan_halted(chan_halted), .tail_kick(tail_kick),
        .cur_load(cur_load), .cur_ptr(cur_ptr), .tail_ptr(tail_ptr), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_addr  = AW'(a);
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = AW'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_done();
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset values
        rd(0, v); check("R1 ctrl", v, 32'h0001_0002);
        rd(1, v); check("R1 stat", v, 32'h0001_0001);
        check("R1 irq", 32'(irq), 0);
        check("R1 halted", 32'(chan_halted), 1);
        check("R1 run", 32'(chan_run), 0);

        // R13 unmapped word
        rd(3, v); check("R13 word3", v, 0);
        rd(7, v); check("R13 word7", v, 0);

        // R4 halted bit not writable
        wr(1, 32'h0000_0003);
        rd(1, v); check("R4 stat halted kept", v, 32'h0001_0001);

        // R2 control write and counter reload
        wr(0, 32'h0005_0000);
        rd(0, v); check("R2 ctrl", v, 32'h0005_0002);
        rd(1, v); check("R2 count", 32'(v[23:16]), 5);

        // R3 start
        wr(0, 32'h0001_0001);
        rd(1, v); check("R3 stat run", 32'(v[1:0]), 0);
        check("R3 run", 32'(chan_run), 1);
        check("R3 halted", 32'(chan_halted), 0);

        // R4 writes to running status ignored
        wr(1, 32'h0000_0003);
        rd(1, v); check("R4 stat running kept", 32'(v[1:0]), 0);

        // R3 engine idle
        eng_idle = 1'b1; tick(1); eng_idle = 1'b0;
        check("R3 idle", 32'(chan_idle), 1);
        rd(1, v); check("R3 stat idle", 32'(v[1:0]), 2);

        // R5 tail write
        wr(4, 32'h0000_ABC0);
        check("R5 kick", 32'(tail_kick), 1);
        check("R5 idle cleared", 32'(chan_idle), 0);
        check("R5 tail_ptr", tail_ptr, 32'h0000_ABC0);
        rd(4, v); check("R5 tail read", v, 32'h0000_ABC0);
        tick(1);
        check("R5 kick single", 32'(tail_kick), 0);

        // R6 current pointer write
        wr(2, 32'h0000_1230);
        check("R6 cur_load", 32'(cur_load), 1);
        check("R6 cur_ptr", cur_ptr, 32'h0000_1230);
        rd(2, v); check("R6 cur read", v, 32'h0000_1230);
        tick(1);
        check("R6 cur_load single", 32'(cur_load), 0);

        // R7 / R11 threshold sweep
        for (int thr = 1; thr <= 4; thr++) begin
            wr(0, (32'(thr) << 16) | 32'h0000_1001);
            wr(1, 32'h0000_3000);
            for (int i = 1; i <= thr; i++) begin
                pulse_done();
                rd(1, v);
                check("R7 hit flag", 32'(v[12]), 32'(i == thr));
                check("R7 count", 32'(v[23:16]), (i == thr) ? 32'(thr) : 32'(thr - i));
                check("R11 irq follows", 32'(irq), 32'(i == thr));
            end
        end

        // R10 write-one-to-clear
        wr(1, 32'h0000_0000);
        rd(1, v); check("R10 zero keeps", 32'(v[12]), 1);
        wr(1, 32'h0000_1000);
        rd(1, v); check("R10 one clears", 32'(v[12]), 0);
        check("R10 irq low", 32'(irq), 0);

        // R11 gating
        wr(0, 32'h0001_0001);
        pulse_done();
        rd(1, v); check("R11 pending", 32'(v[12]), 1);
        check("R11 masked", 32'(irq), 0);
        wr(0, 32'h0001_1001);
        check("R11 enabled", 32'(irq), 1);
        wr(1, 32'h0000_3000);

        // R8 delay sweep
        for (int d = 1; d <= 3; d++) begin
            wr(0, (32'(d) << 24) | 32'h000A_2001);
            wr(1, 32'h0000_3000);
            pulse_done();
            rd(1, v);
            check("R8 timer loaded", 32'(v[31:24]), 32'(d));
            check("R8 count after done", 32'(v[23:16]), 9);
            tick(d * P - 1);
            rd(1, v);
            check("R8 not yet", 32'(v[13]), 0);
            check("R8 timer one", 32'(v[31:24]), 1);
            check("R8 irq not yet", 32'(irq), 0);
            tick(1);
            rd(1, v);
            check("R8 expired", 32'(v[13]), 1);
            check("R8 timer zero", 32'(v[31:24]), 0);
            check("R8 counter reloaded", 32'(v[23:16]), 10);
            check("R8 irq", 32'(irq), 1);
        end

        // R8 zero delay field
        wr(0, 32'h000A_2001);
        wr(1, 32'h0000_3000);
        pulse_done();
        rd(1, v); check("R8 zero delay idle", 32'(v[31:24]), 0);
        tick(20);
        rd(1, v); check("R8 zero delay no irq", 32'(v[13]), 0);

        // R9 restart
        wr(0, 32'h030A_2001);
        wr(1, 32'h0000_3000);
        pulse_done();
        tick(4);
        rd(1, v); check("R9 mid count", 32'(v[31:24]), 2);
        pulse_done();
        rd(1, v); check("R9 restarted", 32'(v[31:24]), 3);
        check("R9 count", 32'(v[23:16]), 8);
        tick(8);
        rd(1, v); check("R9 not yet", 32'(v[13]), 0);
        tick(1);
        rd(1, v); check("R9 expired", 32'(v[13]), 1);

        // R12 soft reset
        wr(0, 32'h0000_0005);
        rd(0, v); check("R12 ctrl in reset", v, 32'h0001_0006);
        rd(1, v); check("R12 stat in reset", v, 32'h0001_0001);
        check("R12 halted", 32'(chan_halted), 1);
        wr(0, 32'h0001_0001);
        rd(0, v); check("R12 bit still set", 32'(v[2]), 1);
        check("R12 run ignored", 32'(chan_halted), 1);
        tick(2);
        rd(0, v); check("R12 bit cleared", 32'(v[2]), 0);
        check("R12 still halted", 32'(chan_halted), 1);
        wr(0, 32'h0001_0001);
        check("R12 restart", 32'(chan_halted), 0);

        // R3 engine halt
        eng_halted = 1'b1; tick(1); eng_halted = 1'b0;
        check("R3 engine halt", 32'(chan_halted), 1);
        rd(1, v); check("R3 stat halt", 32'(v[1:0]), 1);

        report();
    end

endmodule